// File: doc/BRIEF.md
# Subroutine and Stack Bus Sequencer

This block steps an 8-bit processor core through subroutine calls, returns, accumulator pushes and pulls, absolute jumps and single-byte implied instructions. Every clock it puts exactly one bus cycle on a 16-bit address bus. The cycles include the wasted reads that each instruction makes, so a bus trace from this block matches the cycle pattern of a classic 8-bit part. It holds the program counter, an 8-bit stack pointer that stays in one fixed memory page, the accumulator, and the negative and zero flags.

Memory is outside the block and answers in the same cycle. The read data for the address driven in a cycle is sampled at the clock edge that ends that cycle. Writes are signalled by `bus_we_o` with data on `bus_wdata_o`, and are committed by memory at that same edge. Execution starts at `RESET_PC` with the stack pointer at `SP_RESET`.

Top module: `stk_seq_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `bus_addr_o` equals `RESET_PC`, `bus_we_o` is 0, `op_sync_o` is 1, both flags are 0, and the stack pointer is `SP_RESET`, so the first stack access lands at page address `SP_RESET`.
- R2: Opcode 0xEA, and any opcode not listed in R3, R4, R6, R7 or R8, takes two cycles: the fetch at P, then a dummy read at P+1, followed by the next fetch at P+1.
- R3: Opcode 0x4C (jump) takes three cycles: the fetch at P, the target low byte read at P+1, and the target high byte read at P+2. The next fetch is at the target.
- R4: Opcode 0x20 (call) takes six cycles: the fetch at P, the target low read at P+1, a dummy stack read, a push of the return high byte, a push of the return low byte, and the target high read at P+2. The next fetch is at the target.
- R5: The value that a call pushes is P+2, the address of its own last operand byte. The high byte goes first, to the current stack slot, and the low byte goes to the slot one below.
- R6: Opcode 0x60 (return) takes six cycles: the fetch at P, a dummy read at P+1, a dummy stack read, a pull of the low byte, a pull of the high byte, and a dummy read at the pulled address Q. The next fetch is at Q+1.
- R7: Opcode 0x48 (push A) takes three cycles: the fetch at P, a dummy read at P+1, and a write of the accumulator to the stack. The next fetch is at P+1.
- R8: Opcode 0x68 (pull A) takes four cycles: the fetch at P, a dummy read at P+1, a dummy read at the current stack slot, and a read of the slot above, which loads the accumulator. The next fetch is at P+1.
- R9: The stack address is {`STACK_PAGE`, SP}. A push writes at SP and then decrements SP. A pull increments SP first and then reads. SP wraps modulo 256 (0xFF+1 = 0x00), so the address never leaves the stack page.
- R10: After a pull into the accumulator, `flag_n_o` equals bit 7 of the pulled byte and `flag_z_o` is 1 exactly when the byte is zero.
- R11: `bus_we_o` is 1 only during push cycles, and every write address lies in the stack page.
- R12: `op_sync_o` is 1 exactly in opcode fetch cycles, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_data_i | input | 8 | Read data for the address driven in this cycle |
| bus_addr_o | output | 16 | Address of the current bus cycle |
| bus_we_o | output | 1 | 1 when the current cycle is a write |
| bus_wdata_o | output | 8 | Write data, meaningful when `bus_we_o` is 1 |
| op_sync_o | output | 1 | 1 in opcode fetch cycles |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
Two functions can land on the same clock edge: a stack pointer step that wraps past 0xFF, and the accumulator load with its flag update. The first pull runs from a reset pointer of 0xFF and reads page address 0x00, and a later pull returns a zero byte. The bench therefore judges the wrapped address and the loaded value together, through the write data of a following push and through the flags. A second collision is a reset raised during a call's push: the bench checks that the very next cycle is a clean fetch at the start address, with no write pending.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - DATA_W;

  localparam logic [DATA_W-1:0] OP_JSR = 8'h20;
  localparam logic [DATA_W-1:0] OP_RTS = 8'h60;
  localparam logic [DATA_W-1:0] OP_PHA = 8'h48;
  localparam logic [DATA_W-1:0] OP_PLA = 8'h68;
  localparam logic [DATA_W-1:0] OP_JMP = 8'h4C;

  typedef enum logic [2:0] {
    C_IMPL, C_JMP, C_JSR, C_RTS, C_PHA, C_PLA
  } op_cls_e;

  typedef enum logic [4:0] {
    S_FETCH, S_IMP_DUM,
    S_JMP_LO, S_JMP_HI,
    S_JSR_LO, S_JSR_DUM, S_JSR_PSH_H, S_JSR_PSH_L, S_JSR_HI,
    S_RTS_DUM, S_RTS_SDUM, S_RTS_PL, S_RTS_PH, S_RTS_FIX,
    S_PHA_DUM, S_PHA_WR,
    S_PLA_DUM, S_PLA_SDUM, S_PLA_RD
  } seq_st_e;
endpackage

// File: rtl/stk_op_decode.sv
module stk_op_decode
  import stk_pkg::*;
(
  input  logic [DATA_W-1:0] op_i,
  output op_cls_e           cls_o
);
  always_comb begin
    case (op_i)
      OP_JSR:  cls_o = C_JSR;
      OP_RTS:  cls_o = C_RTS;
      OP_PHA:  cls_o = C_PHA;
      OP_PLA:  cls_o = C_PLA;
      OP_JMP:  cls_o = C_JMP;
      default: cls_o = C_IMPL;
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter logic [DATA_W-1:0] SP_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pull_i,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] sp_inc_o,
  output logic [DATA_W-1:0] sp_dec_o
);
  logic [DATA_W-1:0] sp_q;

  assign sp_inc_o = sp_q + 1'b1;
  assign sp_dec_o = sp_q - 1'b1;
  assign sp_o     = sp_q;

  always_ff @(posedge clk) begin
    if (rst)         sp_q <= SP_RESET;
    else if (push_i) sp_q <= sp_dec_o;
    else if (pull_i) sp_q <= sp_inc_o;
  end

  // R9: a step is either a push or a pull, never both
  a_r9_single_move: assert property (@(posedge clk) disable iff (rst)
    !(push_i && pull_i));
endmodule

// File: rtl/stk_seq_core.sv
module stk_seq_core
  import stk_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC   = 16'h0200,
  parameter logic [DATA_W-1:0] SP_RESET   = 8'hFF,
  parameter logic [PAGE_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              op_sync_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);
  seq_st_e           st, nx_st;
  logic [ADDR_W-1:0] pc, nx_pc, nx_addr;
  logic [DATA_W-1:0] acc, tlo, nx_tlo, nx_wd;
  logic              nx_we, ld_acc, sp_push, sp_pull;
  logic [DATA_W-1:0] sp, sp_inc, sp_dec;
  op_cls_e           cls;
  logic [ADDR_W-1:0] stk_cur, stk_inc, stk_dec, rd_tgt;

  stk_op_decode u_dec (.op_i(rd_data_i), .cls_o(cls));

  stk_ptr #(.SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst(rst), .push_i(sp_push), .pull_i(sp_pull),
    .sp_o(sp), .sp_inc_o(sp_inc), .sp_dec_o(sp_dec)
  );

  assign stk_cur = {STACK_PAGE, sp};
  assign stk_inc = {STACK_PAGE, sp_inc};
  assign stk_dec = {STACK_PAGE, sp_dec};
  assign rd_tgt  = {rd_data_i, tlo};

  always_comb begin
    nx_st   = st;
    nx_pc   = pc;
    nx_addr = bus_addr_o;
    nx_we   = 1'b0;
    nx_wd   = bus_wdata_o;
    nx_tlo  = tlo;
    sp_push = 1'b0;
    sp_pull = 1'b0;
    ld_acc  = 1'b0;
    case (st)
      S_FETCH: begin
        nx_pc   = pc + 1'b1;
        nx_addr = pc + 1'b1;
        case (cls)
          C_JMP:   nx_st = S_JMP_LO;
          C_JSR:   nx_st = S_JSR_LO;
          C_RTS:   nx_st = S_RTS_DUM;
          C_PHA:   nx_st = S_PHA_DUM;
          C_PLA:   nx_st = S_PLA_DUM;
          default: nx_st = S_IMP_DUM;
        endcase
      end
      S_IMP_DUM: begin nx_addr = pc; nx_st = S_FETCH; end
      S_JMP_LO: begin
        nx_tlo = rd_data_i; nx_pc = pc + 1'b1; nx_addr = pc + 1'b1;
        nx_st = S_JMP_HI;
      end
      S_JMP_HI: begin nx_pc = rd_tgt; nx_addr = rd_tgt; nx_st = S_FETCH; end
      S_JSR_LO: begin
        nx_tlo = rd_data_i; nx_pc = pc + 1'b1; nx_addr = stk_cur;
        nx_st = S_JSR_DUM;
      end
      S_JSR_DUM: begin
        nx_addr = stk_cur; nx_we = 1'b1; nx_wd = pc[ADDR_W-1:DATA_W];
        nx_st = S_JSR_PSH_H;
      end
      S_JSR_PSH_H: begin
        sp_push = 1'b1; nx_addr = stk_dec; nx_we = 1'b1; nx_wd = pc[DATA_W-1:0];
        nx_st = S_JSR_PSH_L;
      end
      S_JSR_PSH_L: begin sp_push = 1'b1; nx_addr = pc; nx_st = S_JSR_HI; end
      S_JSR_HI: begin nx_pc = rd_tgt; nx_addr = rd_tgt; nx_st = S_FETCH; end
      S_RTS_DUM: begin nx_addr = stk_cur; nx_st = S_RTS_SDUM; end
      S_RTS_SDUM: begin sp_pull = 1'b1; nx_addr = stk_inc; nx_st = S_RTS_PL; end
      S_RTS_PL: begin
        nx_tlo = rd_data_i; sp_pull = 1'b1; nx_addr = stk_inc; nx_st = S_RTS_PH;
      end
      S_RTS_PH: begin nx_pc = rd_tgt; nx_addr = rd_tgt; nx_st = S_RTS_FIX; end
      S_RTS_FIX: begin nx_pc = pc + 1'b1; nx_addr = pc + 1'b1; nx_st = S_FETCH; end
      S_PHA_DUM: begin
        nx_addr = stk_cur; nx_we = 1'b1; nx_wd = acc; nx_st = S_PHA_WR;
      end
      S_PHA_WR: begin sp_push = 1'b1; nx_addr = pc; nx_st = S_FETCH; end
      S_PLA_DUM: begin nx_addr = stk_cur; nx_st = S_PLA_SDUM; end
      S_PLA_SDUM: begin sp_pull = 1'b1; nx_addr = stk_inc; nx_st = S_PLA_RD; end
      S_PLA_RD: begin ld_acc = 1'b1; nx_addr = pc; nx_st = S_FETCH; end
      default: begin nx_addr = pc; nx_st = S_FETCH; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_FETCH;
      pc          <= RESET_PC;
      bus_addr_o  <= RESET_PC;
      bus_we_o    <= 1'b0;
      bus_wdata_o <= '0;
      op_sync_o   <= 1'b1;
      tlo         <= '0;
      acc         <= '0;
      flag_n_o    <= 1'b0;
      flag_z_o    <= 1'b0;
    end else begin
      st          <= nx_st;
      pc          <= nx_pc;
      bus_addr_o  <= nx_addr;
      bus_we_o    <= nx_we;
      bus_wdata_o <= nx_wd;
      op_sync_o   <= (nx_st == S_FETCH);
      tlo         <= nx_tlo;
      if (ld_acc) begin
        acc      <= rd_data_i;
        flag_n_o <= rd_data_i[DATA_W-1];
        flag_z_o <= (rd_data_i == '0);
      end
    end
  end

  // R11: writes stay inside the stack page
  a_r11_write_in_page: assert property (@(posedge clk) disable iff (rst)
    bus_we_o |-> bus_addr_o[ADDR_W-1:DATA_W] == STACK_PAGE);

  // R12: no two fetch cycles back to back
  a_r12_sync_single: assert property (@(posedge clk) disable iff (rst)
    op_sync_o |=> !op_sync_o);

  // R5: low return byte is written one slot below the high byte
  a_r5_push_order: assert property (@(posedge clk) disable iff (rst)
    (st == S_JSR_PSH_H) |=>
      (bus_we_o && bus_addr_o[DATA_W-1:0] == $past(bus_addr_o[DATA_W-1:0]) - 8'd1));

  // R6: after the dummy read at the pulled address, fetch resumes one above it
  a_r6_return_fix: assert property (@(posedge clk) disable iff (rst)
    (st == S_RTS_FIX) |=> (op_sync_o && bus_addr_o == $past(bus_addr_o) + 16'd1));

  // R9: a pull reads the slot above the pre-adjust read, wrapping in page
  a_r9_pull_addr: assert property (@(posedge clk) disable iff (rst)
    (st == S_PLA_SDUM) |=>
      (bus_addr_o == {STACK_PAGE, $past(bus_addr_o[DATA_W-1:0]) + 8'd1}));

  // R10: flags follow the pulled byte
  a_r10_pull_flags: assert property (@(posedge clk) disable iff (rst)
    (st == S_PLA_RD) |=>
      (flag_z_o == ($past(rd_data_i) == 8'h00) && flag_n_o == $past(rd_data_i[DATA_W-1])));
endmodule

// File: tb/stk_seq_core_tb_top.sv
`timescale 1ns/1ps
module stk_seq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rd_data;
  logic [15:0] bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic        op_sync, flag_n, flag_z;
  logic [7:0]  mem [1024];
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  stk_seq_core dut_i (
    .clk(clk), .rst(rst), .rd_data_i(rd_data), .bus_addr_o(bus_addr),
    .bus_we_o(bus_we), .bus_wdata_o(bus_wdata), .op_sync_o(op_sync),
    .flag_n_o(flag_n), .flag_z_o(flag_z)
  );

  assign rd_data = mem[bus_addr[9:0]];
  always @(posedge clk) if (bus_we) mem[bus_addr[9:0]] <= bus_wdata;

  // row: {addr, we, wdata, sync, n, z}
  localparam int NV = 41;
  localparam logic [27:0] VEC [NV] = '{
    {16'h0200,1'b0,8'h00,1'b1,1'b0,1'b0}, {16'h0201,1'b0,8'h00,1'b0,1'b0,1'b0},
    {16'h01FF,1'b0,8'h00,1'b0,1'b0,1'b0}, {16'h0100,1'b0,8'h00,1'b0,1'b0,1'b0},
    {16'h0201,1'b0,8'h00,1'b1,1'b1,1'b0}, {16'h0202,1'b0,8'h00,1'b0,1'b1,1'b0},
    {16'h0100,1'b1,8'h85,1'b0,1'b1,1'b0}, {16'h0202,1'b0,8'h00,1'b1,1'b1,1'b0},
    {16'h0203,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h01FF,1'b0,8'h00,1'b0,1'b1,1'b0},
    {16'h01FF,1'b1,8'h02,1'b0,1'b1,1'b0}, {16'h01FE,1'b1,8'h04,1'b0,1'b1,1'b0},
    {16'h0204,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0210,1'b0,8'h00,1'b1,1'b1,1'b0},
    {16'h0211,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0211,1'b0,8'h00,1'b1,1'b1,1'b0},
    {16'h0212,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0212,1'b0,8'h00,1'b1,1'b1,1'b0},
    {16'h0213,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h01FD,1'b0,8'h00,1'b0,1'b1,1'b0},
    {16'h01FE,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h01FF,1'b0,8'h00,1'b0,1'b1,1'b0},
    {16'h0204,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0205,1'b0,8'h00,1'b1,1'b1,1'b0},
    {16'h0206,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h01FF,1'b0,8'h00,1'b0,1'b1,1'b0},
    {16'h0100,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0206,1'b0,8'h00,1'b1,1'b1,1'b0},
    {16'h0207,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0100,1'b0,8'h00,1'b0,1'b1,1'b0},
    {16'h0101,1'b0,8'h00,1'b0,1'b1,1'b0}, {16'h0207,1'b0,8'h00,1'b1,1'b0,1'b1},
    {16'h0208,1'b0,8'h00,1'b0,1'b0,1'b1}, {16'h0101,1'b1,8'h00,1'b0,1'b0,1'b1},
    {16'h0208,1'b0,8'h00,1'b1,1'b0,1'b1}, {16'h0209,1'b0,8'h00,1'b0,1'b0,1'b1},
    {16'h020A,1'b0,8'h00,1'b0,1'b0,1'b1}, {16'h0208,1'b0,8'h00,1'b1,1'b0,1'b1},
    {16'h0209,1'b0,8'h00,1'b0,1'b0,1'b1}, {16'h020A,1'b0,8'h00,1'b0,1'b0,1'b1},
    {16'h0208,1'b0,8'h00,1'b1,1'b0,1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    if (i <= 3)  return "R8";
    if (i <= 6)  return "R7";
    if (i <= 12) return "R4";
    if (i <= 16) return "R2";
    if (i <= 22) return "R6";
    if (i <= 33) return "R9";
    return "R3";
  endfunction

  task automatic load_prog();
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    mem[10'h100] = 8'h85;
    mem[10'h200] = 8'h68; mem[10'h201] = 8'h48;
    mem[10'h202] = 8'h20; mem[10'h203] = 8'h10; mem[10'h204] = 8'h02;
    mem[10'h205] = 8'h68; mem[10'h206] = 8'h68; mem[10'h207] = 8'h48;
    mem[10'h208] = 8'h4C; mem[10'h209] = 8'h08; mem[10'h20A] = 8'h02;
    mem[10'h210] = 8'hEA; mem[10'h211] = 8'h33; mem[10'h212] = 8'h60;
  endtask

  task automatic check_row(input int i);
    logic [27:0] v;
    v = VEC[i];
    chk(row_tag(i), "addr", bus_addr, v[27:12]);
    chk((i == 10 || i == 11) ? "R5" : "R11", "we", {15'd0, bus_we}, {15'd0, v[11]});
    if (v[11]) chk((i == 10 || i == 11) ? "R5" : "R7", "wdata", {8'd0, bus_wdata}, {8'd0, v[10:3]});
    chk("R12", "sync", {15'd0, op_sync}, {15'd0, v[2]});
    chk("R10", "flags", {14'd0, flag_n, flag_z}, {14'd0, v[1:0]});
  endtask

  initial begin
    load_prog();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk("R1", "addr in reset", bus_addr, 16'h0200);
    chk("R1", "we in reset", {15'd0, bus_we}, 16'd0);
    chk("R1", "sync in reset", {15'd0, op_sync}, 16'd1);
    chk("R1", "flags in reset", {14'd0, flag_n, flag_z}, 16'd0);
    rst = 1'b0;
    #1;
    check_row(0);
    for (int i = 1; i < NV; i++) begin
      @(negedge clk);
      check_row(i);
    end
    chk("R7", "push of zero acc stored", {8'd0, mem[10'h101]}, 16'h0000);
    chk("R5", "return high stored", {8'd0, mem[10'h1FF]}, 16'h0002);
    chk("R5", "return low stored", {8'd0, mem[10'h1FE]}, 16'h0004);

    // R1: second reset restores SP, so the first pull again reads 0x0100
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    for (int i = 0; i < 11; i++) begin
      if (i > 0) @(negedge clk);
      check_row(i);
    end
    // row 10 is a call push write; reset lands during it
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "addr after mid-push reset", bus_addr, 16'h0200);
    chk("R1", "we after mid-push reset", {15'd0, bus_we}, 16'd0);
    chk("R1", "flags after mid-push reset", {14'd0, flag_n, flag_z}, 16'd0);
    rst = 1'b0;
    #1;
    chk("R1", "first cycle after release", bus_addr, 16'h0200);
    @(negedge clk);
    chk("R2", "pull dummy after release", bus_addr, 16'h0201);
    @(negedge clk);
    chk("R9", "stack slot after re-reset", bus_addr, 16'h01FF);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule